// File: doc/BRIEF.md
# PLL Programming Sequencer

This controller takes a requested PLL setting and applies it to a two-register PLL control pair in an order that keeps the output glitch-free. The setting is an input divider M, a feedback multiplier N, a post-divide exponent P and a charge-pump code. The control pair is a base register holding the dividers and control bits, and a misc register holding the charge pump. First the PLL is parked in bypass with its new dividers. Then the charge pump is loaded and the PLL is enabled while still bypassed. Finally bypass is released. After that, the block waits a fixed number of microsecond ticks for lock before it reports ready.

The controller also computes the frequency the PLL will produce. It uses a 2-bit reference-frequency code and reports the result in kHz. When built as the peripheral-PLL instance, it reads back the current base register. If that register shows a previous configuration (override bit set), the block only compares and never writes. A match reports "already correct" and a mismatch reports an error.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset, busy_o, ready_o, match_o, err_o and wr_en_o are all 0.
- R2: An accepted start with M != 0 and the override bit (cur_base_i bit 28) clear first writes the base register (wr_sel_o = 0). The word has M in bits [4:0], N in [17:8], P in [22:20], override bit 28 = 1, enable bit 30 = 0, bypass bit 31 = 1, and all other bits 0.
- R3: The three writes that follow come in consecutive cycles. First comes the misc register (wr_sel_o = 1) with the charge pump in bits [11:8] and all other bits 0. Next comes the base word with enable = 1 and bypass = 1. Last comes the base word with enable = 1 and bypass = 0. No other write occurs in the sequence.
- R4: ready_o rises only after STAB_US tick_i pulses have been counted in cycles after the bypass-release write. busy_o stays 1 from acceptance until then.
- R5: When ready_o is 1, freq_khz_o equals floor(ref_khz × N / M) >> P. ref_khz is 13000, 19200, 12000 or 26000 for ref_code_i = 0, 1, 2, 3. freq_khz_o holds while ready_o stays 1.
- R6: If the override bit is set at acceptance, no write is made. The compare covers the defined base fields (M, N, P, override = 1, enable = 1, bypass = 0). On a match, the block ends with ready_o = 1, match_o = 1 and err_o = 0.
- R7: If the override bit is set and the compare fails, no write is made. The block ends with err_o = 1, ready_o = 0 and match_o = 0.
- R8: A start with M = 0 is rejected. No write is made, err_o = 1 and ready_o = 0.
- R9: A start_i pulse while busy_o = 1 is ignored. The running sequence keeps its latched setting and its write count.
- R10: Acceptance of a new start clears err_o, ready_o and match_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while not busy |
| cfg_m_i | input | 5 | Input divider M |
| cfg_n_i | input | 10 | Feedback multiplier N |
| cfg_p_i | input | 3 | Post-divide exponent P |
| cfg_cp_i | input | 4 | Charge-pump code |
| ref_code_i | input | 2 | Reference-frequency code |
| tick_i | input | 1 | One-cycle microsecond tick |
| cur_base_i | input | 32 | Current base register readback |
| wr_en_o | output | 1 | Register write strobe |
| wr_sel_o | output | 1 | 0 = base register, 1 = misc register |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | PLL configured and stable |
| match_o | output | 1 | Configuration was already correct |
| err_o | output | 1 | Request rejected or compare mismatch |
| freq_khz_o | output | 25 | Computed output frequency in kHz |

## Verification
Several cases are aimed at wrong ordering and wrong bits. A release write sent before the enable write, or a missing override bit, shows up as a wrong word in the captured write list. A lock delay that counts ticks too early or misses one makes ready_o rise at the wrong tick count. A repeated setting must produce zero writes; a design that reprograms instead leaks four writes. A single-field mismatch must raise the error without touching the PLL. A start pulse in the middle of the wait must not restart the sequence. A design that accepts it writes a second set of words or reports the frequency of the wrong setting. The frequency check spans M = 1, maximum N and P = 7, so truncation or shift mistakes show.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int REG_W   = 32;
  localparam int M_LSB   = 0;
  localparam int N_LSB   = 8;
  localparam int P_LSB   = 20;
  localparam int OVR_BIT = 28;
  localparam int EN_BIT  = 30;
  localparam int BYP_BIT = 31;
  localparam int CP_LSB  = 8;

  localparam int REF0_KHZ = 13000;
  localparam int REF1_KHZ = 19200;
  localparam int REF2_KHZ = 12000;
  localparam int REF3_KHZ = 26000;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMP,
    S_WBYP,
    S_WCP,
    S_WEN,
    S_WREL,
    S_WAIT,
    S_CALC
  } seq_state_t;
endpackage

// File: rtl/pll_ref_rom.sv
module pll_ref_rom
  import pll_seq_pkg::*;
#(
  parameter int REF_W = 15
) (
  input  logic [1:0]       code_i,
  output logic [REF_W-1:0] khz_o
);
  always_comb begin
    unique case (code_i)
      2'd0:    khz_o = REF_W'(REF0_KHZ);
      2'd1:    khz_o = REF_W'(REF1_KHZ);
      2'd2:    khz_o = REF_W'(REF2_KHZ);
      default: khz_o = REF_W'(REF3_KHZ);
    endcase
  end
endmodule

// File: rtl/pll_udiv.sv
module pll_udiv #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             loaded_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q    <= '0;
      rem_q    <= '0;
      den_q    <= '0;
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (start_i) begin
      quo_q    <= num_i;
      rem_q    <= '0;
      den_q    <= den_i;
      cnt_q    <= CNT_W'(NUM_W);
      loaded_q <= 1'b1;
    end else if (cnt_q != '0) begin
      rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_q <= {quo_q[NUM_W-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo_o  = quo_q;
  assign done_o = loaded_q && (cnt_q == '0);
endmodule

// File: rtl/pll_stab_cnt.sv
module pll_stab_cnt #(
  parameter int STAB_US = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(STAB_US + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STAB_US);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int M_W       = 5,
  parameter int N_W       = 10,
  parameter int P_W       = 3,
  parameter int CP_W      = 4,
  parameter int REF_W     = 15,
  parameter int STAB_US   = 300,
  parameter bit IS_PERIPH = 1'b1,
  localparam int F_W      = REF_W + N_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [M_W-1:0]   cfg_m_i,
  input  logic [N_W-1:0]   cfg_n_i,
  input  logic [P_W-1:0]   cfg_p_i,
  input  logic [CP_W-1:0]  cfg_cp_i,
  input  logic [1:0]       ref_code_i,
  input  logic             tick_i,
  input  logic [REG_W-1:0] cur_base_i,
  output logic             wr_en_o,
  output logic             wr_sel_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             match_o,
  output logic             err_o,
  output logic [F_W-1:0]   freq_khz_o
);
  localparam logic OVR_VAL = IS_PERIPH;

  function automatic logic [REG_W-1:0] base_word(
    input logic [M_W-1:0] m, input logic [N_W-1:0] n, input logic [P_W-1:0] p,
    input logic ovr, input logic en, input logic byp);
    logic [REG_W-1:0] w;
    w = '0;
    w[M_LSB +: M_W] = m;
    w[N_LSB +: N_W] = n;
    w[P_LSB +: P_W] = p;
    w[OVR_BIT]      = ovr;
    w[EN_BIT]       = en;
    w[BYP_BIT]      = byp;
    return w;
  endfunction

  seq_state_t       state_q;
  logic [M_W-1:0]   m_q;
  logic [N_W-1:0]   n_q;
  logic [P_W-1:0]   p_q;
  logic [CP_W-1:0]  cp_q;
  logic             ready_q, match_q, err_q, hit_q;
  logic [F_W-1:0]   freq_q;

  logic             accept;
  logic             cold_ok;
  logic [REG_W-1:0] fld_mask, cmp_word;
  logic             cmp_hit;
  logic [REF_W-1:0] ref_khz;
  logic [F_W-1:0]   num, quo;
  logic             div_done, stab_done;

  assign busy_o  = (state_q != S_IDLE);
  assign accept  = start_i && !busy_o;
  assign cold_ok = (cfg_m_i != '0);

  pll_ref_rom #(.REF_W(REF_W)) u_ref (
    .code_i (ref_code_i),
    .khz_o  (ref_khz)
  );

  assign num = F_W'(ref_khz) * F_W'(cfg_n_i);

  pll_udiv #(.NUM_W(F_W), .DEN_W(M_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept && cold_ok),
    .num_i   (num),
    .den_i   (cfg_m_i),
    .quo_o   (quo),
    .done_o  (div_done)
  );

  pll_stab_cnt #(.STAB_US(STAB_US)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .tick_i (tick_i && state_q == S_WAIT),
    .done_o (stab_done)
  );

  // compare against defined fields only; other bits of the register are don't-care
  always_comb begin
    fld_mask = base_word('1, '1, '1, 1'b1, 1'b1, 1'b1);
    cmp_word = base_word(m_q, n_q, p_q, 1'b1, 1'b1, 1'b0);
    cmp_hit  = ((cur_base_i & fld_mask) == cmp_word);
  end

  logic ovr_seen;
  generate
    if (IS_PERIPH) begin : g_ovr
      assign ovr_seen = cur_base_i[OVR_BIT];
    end else begin : g_no_ovr
      assign ovr_seen = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      m_q     <= '0;
      n_q     <= '0;
      p_q     <= '0;
      cp_q    <= '0;
      ready_q <= 1'b0;
      match_q <= 1'b0;
      err_q   <= 1'b0;
      hit_q   <= 1'b0;
      freq_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          m_q     <= cfg_m_i;
          n_q     <= cfg_n_i;
          p_q     <= cfg_p_i;
          cp_q    <= cfg_cp_i;
          ready_q <= 1'b0;
          match_q <= 1'b0;
          hit_q   <= 1'b0;
          err_q   <= !cold_ok;
          if (cold_ok) state_q <= ovr_seen ? S_CMP : S_WBYP;
        end
        S_CMP: begin
          if (cmp_hit) begin
            hit_q   <= 1'b1;
            state_q <= S_CALC;
          end else begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_WBYP: state_q <= S_WCP;
        S_WCP:  state_q <= S_WEN;
        S_WEN:  state_q <= S_WREL;
        S_WREL: state_q <= S_WAIT;
        S_WAIT: if (stab_done) state_q <= S_CALC;
        S_CALC: if (div_done) begin
          freq_q  <= quo >> p_q;
          ready_q <= 1'b1;
          match_q <= hit_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_sel_o  = 1'b0;
    wr_data_o = '0;
    unique case (state_q)
      S_WBYP: begin
        wr_en_o   = 1'b1;
        wr_data_o = base_word(m_q, n_q, p_q, OVR_VAL, 1'b0, 1'b1);
      end
      S_WCP: begin
        wr_en_o   = 1'b1;
        wr_sel_o  = 1'b1;
        wr_data_o[CP_LSB +: CP_W] = cp_q;
      end
      S_WEN: begin
        wr_en_o   = 1'b1;
        wr_data_o = base_word(m_q, n_q, p_q, OVR_VAL, 1'b1, 1'b1);
      end
      S_WREL: begin
        wr_en_o   = 1'b1;
        wr_data_o = base_word(m_q, n_q, p_q, OVR_VAL, 1'b1, 1'b0);
      end
      default: ;
    endcase
  end

  assign ready_o    = ready_q;
  assign match_o    = match_q;
  assign err_o      = err_q;
  assign freq_khz_o = freq_q;
endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk
  import pll_seq_pkg::*;
#(
  parameter int STAB_US = 300,
  parameter int F_W     = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             tick_i,
  input logic             wr_en_o,
  input logic             wr_sel_o,
  input logic [REG_W-1:0] wr_data_o,
  input logic             busy_o,
  input logic             ready_o,
  input logic             match_o,
  input logic             err_o,
  input logic [F_W-1:0]   freq_khz_o
);
  logic        prog_seen;
  logic [31:0] tcnt;
  logic        rel_wr;

  assign rel_wr = wr_en_o && !wr_sel_o && wr_data_o[EN_BIT] && !wr_data_o[BYP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_seen <= 1'b0;
      tcnt      <= '0;
    end else if (start_i && !busy_o) begin
      prog_seen <= 1'b0;
      tcnt      <= '0;
    end else begin
      if (rel_wr) prog_seen <= 1'b1;
      if (prog_seen && tick_i && busy_o && tcnt != 32'hFFFF_FFFF) tcnt <= tcnt + 1;
    end
  end

  // R2
  first_wr_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) && wr_en_o |-> !wr_sel_o && wr_data_o[BYP_BIT] && !wr_data_o[EN_BIT]);
  // R3
  wr_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);
  // R3
  misc_then_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && wr_sel_o |=> wr_en_o && !wr_sel_o && wr_data_o[EN_BIT] && wr_data_o[BYP_BIT]);
  // R3
  enable_then_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !wr_sel_o && wr_data_o[EN_BIT] && wr_data_o[BYP_BIT]
    |=> wr_en_o && !wr_sel_o && wr_data_o[EN_BIT] && !wr_data_o[BYP_BIT]);
  // R4
  stab_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) && prog_seen |-> tcnt >= STAB_US);
  // R4
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !busy_o && !err_o);
  // R5
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && $past(ready_o) |-> $stable(freq_khz_o));
  // R6
  match_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ready_o);
endmodule

bind pll_prog_seq pll_prog_seq_chk #(.STAB_US(STAB_US), .F_W(F_W)) u_chk (.*);

// File: tb/pll_prog_seq_test.sv
`timescale 1ns/1ps
module pll_prog_seq_test;
  localparam int STAB = 300;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  cfg_m_i = '0;
  logic [9:0]  cfg_n_i = '0;
  logic [2:0]  cfg_p_i = '0;
  logic [3:0]  cfg_cp_i = '0;
  logic [1:0]  ref_code_i = '0;
  logic        tick_i = 1'b0;
  logic [31:0] base_q = '0;
  logic [31:0] misc_q = '0;
  logic        clr_base = 1'b0;
  logic        wr_en_o, wr_sel_o, busy_o, ready_o, match_o, err_o;
  logic [31:0] wr_data_o;
  logic [24:0] freq_khz_o;

  int nchk = 0, nfail = 0;
  int nw, tk;
  logic [31:0] wd [8];
  logic        ws [8];

  always #5 clk_i = ~clk_i;

  pll_prog_seq #(.STAB_US(STAB)) uut (
    .clk_i, .rst_ni, .start_i, .cfg_m_i, .cfg_n_i, .cfg_p_i, .cfg_cp_i,
    .ref_code_i, .tick_i, .cur_base_i(base_q), .wr_en_o, .wr_sel_o, .wr_data_o,
    .busy_o, .ready_o, .match_o, .err_o, .freq_khz_o
  );

  // register pair model
  always @(posedge clk_i) begin
    if (clr_base) base_q <= '0;
    else if (wr_en_o && !wr_sel_o) base_q <= wr_data_o;
    if (wr_en_o && wr_sel_o) misc_q <= wr_data_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_khz(input int rc);
    case (rc)
      0: return 13000;
      1: return 19200;
      2: return 12000;
      default: return 26000;
    endcase
  endfunction

  function automatic longint exp_freq(input int m, n, p, rc);
    return (ref_khz(rc) * n / m) >> p;
  endfunction

  function automatic logic [31:0] exp_base(input int m, n, p, en, byp);
    logic [31:0] w;
    w = '0;
    w[4:0] = m[4:0]; w[17:8] = n[9:0]; w[22:20] = p[2:0];
    w[28] = 1'b1; w[30] = en[0]; w[31] = byp[0];
    return w;
  endfunction

  task automatic cold();
    @(negedge clk_i); clr_base = 1'b1;
    @(negedge clk_i); clr_base = 1'b0;
  endtask

  task automatic run(input int m, n, p, cp, rc, input int mid_at, input int mid_m);
    bit counting, rel;
    @(negedge clk_i);
    cfg_m_i = m[4:0]; cfg_n_i = n[9:0]; cfg_p_i = p[2:0];
    cfg_cp_i = cp[3:0]; ref_code_i = rc[1:0]; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; nw = 0; tk = 0; counting = 0;
    chk(err_o == 1'b0 || m == 0, "R10", "err cleared on accept", err_o, 0);
    chk(ready_o == 1'b0, "R10", "ready cleared on accept", ready_o, 0);
    for (int i = 0; i < 4000; i++) begin
      if (!busy_o) break;
      if (i == mid_at) begin start_i = 1'b1; cfg_m_i = mid_m[4:0]; end
      else begin start_i = 1'b0; cfg_m_i = m[4:0]; end
      rel = 0;
      if (wr_en_o) begin
        if (nw < 8) begin wd[nw] = wr_data_o; ws[nw] = wr_sel_o; end
        nw++;
        rel = !wr_sel_o && wr_data_o[30] && !wr_data_o[31];
      end
      tick_i = (i % 5 == 0);
      if (counting && tick_i) tk++;
      if (rel) counting = 1;
      @(negedge clk_i);
    end
    start_i = 1'b0; tick_i = 1'b0; cfg_m_i = m[4:0];
    chk(!busy_o, "R4", "sequence finished", busy_o, 0);
  endtask

  task automatic check_prog(input int m, n, p, cp, rc);
    chk(nw == 4, "R3", "write count", nw, 4);
    chk(ws[0] == 1'b0 && wd[0] == exp_base(m, n, p, 0, 1), "R2", "bypass write", wd[0], exp_base(m, n, p, 0, 1));
    chk(ws[1] == 1'b1 && wd[1] == (32'(cp) << 8), "R3", "charge pump write", wd[1], 32'(cp) << 8);
    chk(ws[2] == 1'b0 && wd[2] == exp_base(m, n, p, 1, 1), "R3", "enable write", wd[2], exp_base(m, n, p, 1, 1));
    chk(ws[3] == 1'b0 && wd[3] == exp_base(m, n, p, 1, 0), "R3", "release write", wd[3], exp_base(m, n, p, 1, 0));
    chk(tk >= STAB && tk <= STAB + 1, "R4", "ticks before ready", tk, STAB);
    chk(ready_o && !err_o && !match_o, "R4", "ready after program", {ready_o, err_o, match_o}, 4);
    chk(64'(freq_khz_o) == exp_freq(m, n, p, rc), "R5", "frequency", freq_khz_o, exp_freq(m, n, p, rc));
  endtask

  initial begin
    #(10 * 190000);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int m, n, p, cp, rc;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    // R1
    chk(!busy_o && !ready_o && !match_o && !err_o && !wr_en_o, "R1", "reset outputs",
        {busy_o, ready_o, match_o, err_o, wr_en_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !ready_o && !wr_en_o, "R1", "idle after reset", {busy_o, ready_o, wr_en_o}, 0);

    // directed program: 12 MHz ref, M=12 N=432 P=1 -> 216000 kHz
    run(12, 432, 1, 8, 2, -1, 0);
    check_prog(12, 432, 1, 8, 2);
    chk(freq_khz_o == 25'd216000, "R5", "directed frequency", freq_khz_o, 216000);

    // R6: repeat identical setting -> compare only, match
    run(12, 432, 1, 8, 2, -1, 0);
    chk(nw == 0, "R6", "no writes on match", nw, 0);
    chk(ready_o && match_o && !err_o, "R6", "match flags", {ready_o, match_o, err_o}, 6);
    chk(freq_khz_o == 25'd216000, "R5", "frequency on match", freq_khz_o, 216000);

    // R7: mismatch in N
    run(12, 433, 1, 8, 2, -1, 0);
    chk(nw == 0, "R7", "no writes on mismatch", nw, 0);
    chk(err_o && !ready_o && !match_o, "R7", "mismatch flags", {err_o, ready_o, match_o}, 4);
    chk(base_q == exp_base(12, 432, 1, 1, 0), "R7", "base untouched", base_q, exp_base(12, 432, 1, 1, 0));

    // R8: M = 0 on a cold PLL
    cold();
    run(0, 100, 0, 3, 0, -1, 0);
    chk(nw == 0, "R8", "no writes for M=0", nw, 0);
    chk(err_o && !ready_o, "R8", "M=0 error", {err_o, ready_o}, 2);
    chk(base_q == 32'd0 && misc_q[11:8] == 4'd8, "R8", "registers untouched", base_q, 0);

    // R10: good start after error clears err
    run(1, 1023, 7, 15, 3, -1, 0);
    check_prog(1, 1023, 7, 15, 3);

    // R9: start during wait ignored
    cold();
    run(5, 200, 2, 4, 1, 150, 9);
    check_prog(5, 200, 2, 4, 1);

    // random cold programs and repeats
    for (int k = 0; k < 10; k++) begin
      m  = 1 + ($urandom % 31);
      n  = 1 + ($urandom % 1023);
      p  = $urandom % 8;
      cp = $urandom % 16;
      rc = $urandom % 4;
      cold();
      run(m, n, p, cp, rc, -1, 0);
      check_prog(m, n, p, cp, rc);
      if (k % 3 == 0) begin
        run(m, n, p, cp, rc, -1, 0);
        chk(nw == 0 && match_o && ready_o, "R6", "random repeat match", nw, 0);
        chk(64'(freq_khz_o) == exp_freq(m, n, p, rc), "R5", "random repeat freq",
            freq_khz_o, exp_freq(m, n, p, rc));
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule